// File: doc/BRIEF.md
# Encoded I/O Cycle Translator

This bridge sits between a fast processor bus and a slow 32-bit I/O bus of the x86 style, which in turn feeds an ISA interface. The processor cannot signal the kind of bus cycle it wants, so it places that choice in three high address bits. The bridge decodes this 3-bit code into the status lines memory/IO, data/control, write/read and bus lock. The processor also cannot drive its low longword address bits. Three other high address bits therefore stand in for I/O address bits [4:2], and a 4-bit field in the lowest address bits gives the byte lanes.

The bridge makes the I/O bus clock by dividing the system clock by three. All I/O bus outputs move only on that slow clock. An I/O cycle opens with a one-I/O-clock address strobe. It then waits for an active-low ready and only after that acknowledges the processor. Read data is returned replicated into both halves of the 64-bit word. Because the cycle type travels with every address, no mode state has to be saved across interrupts.

Top module: `iocyc_bridge`

## Requirements
- R1: The code in cpu_addr[32:30] sets {io_mio, io_dc, io_wr, locked} as follows: 000 memory read {1,1,0,0}, 001 memory write {1,1,1,0}, 010 I/O read {0,1,0,0}, 011 I/O write {0,1,1,0}, 100 interrupt acknowledge {0,0,0,0}, 101 halt/special {1,0,1,0}, 110 locked memory read {1,1,0,1}, 111 locked memory write {1,1,1,1}. io_lock_n is the inverse of locked and goes high again at the edge that acknowledges the cycle.
- R2: io_addr[4:2] equals cpu_addr[29:27] and io_addr[26:5] equals cpu_addr[26:5].
- R3: io_be_n is the bitwise inverse of the lane mask cpu_addr[3:0], where bit n enables byte lane n. A mask of 0000 enables all four lanes (io_be_n = 0000). At least one lane is therefore active on every cycle.
- R4: io_clk is high for one system clock in every three. All I/O bus outputs change only at the system clock edges where io_clk rises.
- R5: A pending request is taken at the next io_clk rise. io_ads_n then goes low for exactly one I/O clock (three system clocks).
- R6: cpu_ack is a one-system-clock pulse. It is raised at the first I/O clock edge, at least two after the strobe starts, at which io_rdy_n is sampled low. With ready already low it rises six system clocks after io_ads_n falls.
- R7: Each I/O clock edge at which io_rdy_n is sampled high adds three system clocks before cpu_ack. Status, address, byte enables and write data stay unchanged throughout.
- R8: io_wdata is cpu_wdata[63:32] when cpu_addr[4] is 1, else cpu_wdata[31:0]. On cycles with io_wr = 0, cpu_rdata holds {io_rdata, io_rdata} as sampled on the acknowledging edge.
- R9: In reset io_ads_n = 1, io_lock_n = 1, io_be_n = 1111, io_clk = 0 and cpu_ack = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor cycle request, held until cpu_ack |
| cpu_addr | input | 33 | Code [32:30], low-address substitute [29:27], address [26:5], half select [4], lane mask [3:0] |
| cpu_wdata | input | 64 | Processor write data |
| cpu_ack | output | 1 | One-clock cycle acknowledge |
| cpu_rdata | output | 64 | Replicated read data |
| io_clk | output | 1 | I/O bus clock (system clock / 3) |
| io_ads_n | output | 1 | Address strobe, active low |
| io_mio | output | 1 | 1 memory, 0 I/O |
| io_dc | output | 1 | 1 data, 0 control |
| io_wr | output | 1 | 1 write, 0 read |
| io_lock_n | output | 1 | Bus lock, active low |
| io_addr | output | 25 | I/O longword address bits [26:2] |
| io_be_n | output | 4 | Byte enables, active low |
| io_wdata | output | 32 | I/O write data |
| io_rdata | input | 32 | I/O read data |
| io_rdy_n | input | 1 | Cycle ready, active low |

## Verification
The bench first waits for io_ads_n to fall at a falling clock edge. That first sample is one half clock after the io_clk rise that took the request. Status, address, byte enables and write data are checked there. io_ads_n is due high again at the third falling edge after that. The bench drives io_rdy_n low at falling edge 3+3w, where w is the number of wait states wanted. It then expects cpu_ack exactly at falling edge 6+3w, never earlier, and low again one clock later. The same sweep checks that nothing on the I/O side moves while the cycle is held.

// File: rtl/iocyc_bridge.sv
module iocyc_bridge #(
  parameter int DIV = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic [32:0] cpu_addr,
  input  logic [63:0] cpu_wdata,
  output logic        cpu_ack,
  output logic [63:0] cpu_rdata,
  output logic        io_clk,
  output logic        io_ads_n,
  output logic        io_mio,
  output logic        io_dc,
  output logic        io_wr,
  output logic        io_lock_n,
  output logic [26:2] io_addr,
  output logic [3:0]  io_be_n,
  output logic [31:0] io_wdata,
  input  logic [31:0] io_rdata,
  input  logic        io_rdy_n
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [1:0] {IDLE, STROBE, HOLD} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic          ce;
  logic [3:0]    dec;
  logic [3:0]    mask;

  assign ce   = (cnt == CW'(DIV - 1));
  assign mask = cpu_addr[3:0];

  always_comb begin
    case (cpu_addr[32:30])
      3'd0:    dec = 4'b1100;
      3'd1:    dec = 4'b1110;
      3'd2:    dec = 4'b0100;
      3'd3:    dec = 4'b0110;
      3'd4:    dec = 4'b0000;
      3'd5:    dec = 4'b1010;
      3'd6:    dec = 4'b1101;
      default: dec = 4'b1111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      io_clk    <= 1'b0;
      st        <= IDLE;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
      io_ads_n  <= 1'b1;
      io_mio    <= 1'b0;
      io_dc     <= 1'b0;
      io_wr     <= 1'b0;
      io_lock_n <= 1'b1;
      io_addr   <= '0;
      io_be_n   <= 4'hF;
      io_wdata  <= '0;
    end else begin
      cnt     <= ce ? '0 : cnt + 1'b1;
      io_clk  <= ce;
      cpu_ack <= 1'b0;
      if (ce) begin
        case (st)
          IDLE: if (cpu_req) begin
            io_ads_n  <= 1'b0;
            {io_mio, io_dc, io_wr} <= dec[3:1];
            io_lock_n <= ~dec[0];
            io_addr   <= {cpu_addr[26:5], cpu_addr[29:27]};
            io_be_n   <= (mask == 4'h0) ? 4'h0 : ~mask;
            io_wdata  <= cpu_addr[4] ? cpu_wdata[63:32] : cpu_wdata[31:0];
            st        <= STROBE;
          end
          STROBE: begin
            io_ads_n <= 1'b1;
            st       <= HOLD;
          end
          default: if (!io_rdy_n) begin
            cpu_ack   <= 1'b1;
            io_lock_n <= 1'b1;
            if (!io_wr) cpu_rdata <= {2{io_rdata}};
            st        <= IDLE;
          end
        endcase
      end
    end
  end
endmodule

module iocyc_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce,
  input logic        cpu_req,
  input logic        cpu_ack,
  input logic        io_clk,
  input logic        io_ads_n,
  input logic        io_mio,
  input logic        io_dc,
  input logic        io_wr,
  input logic        io_lock_n,
  input logic [26:2] io_addr,
  input logic [3:0]  io_be_n,
  input logic [31:0] io_wdata,
  input logic        io_rdy_n
);
  assert_out_on_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ce) |-> $stable({io_ads_n, io_mio, io_dc, io_wr, io_lock_n, io_addr, io_be_n, io_wdata}));
  assert_clk_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_clk |=> !io_clk);
  assert_lane_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_ads_n |-> (io_be_n != 4'hF));
  assert_strobe_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_ads_n) |-> $past(cpu_req));
  assert_ack_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> (!$past(io_rdy_n) && $past(ce)));
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
endmodule

bind iocyc_bridge iocyc_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
  .io_clk(io_clk), .io_ads_n(io_ads_n), .io_mio(io_mio), .io_dc(io_dc),
  .io_wr(io_wr), .io_lock_n(io_lock_n), .io_addr(io_addr), .io_be_n(io_be_n),
  .io_wdata(io_wdata), .io_rdy_n(io_rdy_n)
);

// File: tb/iocyc_bridge_test.sv
module iocyc_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [32:0] cpu_addr = '0;
  logic [63:0] cpu_wdata = '0;
  logic        cpu_ack;
  logic [63:0] cpu_rdata;
  logic        io_clk, io_ads_n, io_mio, io_dc, io_wr, io_lock_n;
  logic [26:2] io_addr;
  logic [3:0]  io_be_n;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata = '0;
  logic        io_rdy_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iocyc_bridge uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .io_clk(io_clk), .io_ads_n(io_ads_n), .io_mio(io_mio), .io_dc(io_dc),
    .io_wr(io_wr), .io_lock_n(io_lock_n), .io_addr(io_addr), .io_be_n(io_be_n),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdy_n(io_rdy_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_stat(input int code);
    case (code)
      0: return 4'b1100;
      1: return 4'b1110;
      2: return 4'b0100;
      3: return 4'b0110;
      4: return 4'b0000;
      5: return 4'b1010;
      6: return 4'b1101;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic do_cycle(input int code, input int hi, input int mask, input int w);
    logic [21:0] up;
    logic [63:0] wd;
    logic [31:0] rd;
    logic [3:0]  st;
    logic [3:0]  be;
    logic [31:0] wexp;
    logic        half;
    logic [40:0] snap;
    int          seen;
    bit          moved;
    bit          early;
    int          ack_at;
    up   = 22'((code * 37 + hi * 11 + mask * 3) * 12345 + 7);
    half = 1'(code ^ mask);
    wd   = {32'hC0DE0000 | 32'(code * 256 + mask), 32'h0BAD0000 | 32'(hi * 16 + mask)};
    rd   = 32'h5A000000 | 32'(code * 4096 + hi * 256 + mask);
    st   = exp_stat(code);
    be   = (mask == 0) ? 4'h0 : ~4'(mask);
    wexp = half ? wd[63:32] : wd[31:0];
    ack_at = 6 + 3 * w;

    @(negedge clk);
    cpu_addr  = {3'(code), 3'(hi), up, half, 4'(mask)};
    cpu_wdata = wd;
    io_rdata  = rd;
    cpu_req   = 1'b1;
    io_rdy_n  = 1'b1;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!io_ads_n) begin seen = 1; break; end
    end
    chk("R5 strobe start", 64'(seen), 64'd1);
    chk("R4 io_clk rise with outputs", 64'(io_clk), 64'd1);
    chk("R1 status", 64'({io_mio, io_dc, io_wr, ~io_lock_n}), 64'(st));
    chk("R2 address", 64'(io_addr), 64'({up, 3'(hi)}));
    chk("R3 byte enables", 64'(io_be_n), 64'(be));
    chk("R8 write data", 64'(io_wdata), 64'(wexp));
    snap = {io_mio, io_dc, io_wr, io_addr, io_be_n, io_wdata[7:0]};
    moved = 1'b0;
    early = 1'b0;
    for (int k = 1; k < ack_at; k++) begin
      @(negedge clk);
      if (cpu_ack) early = 1'b1;
      if ({io_mio, io_dc, io_wr, io_addr, io_be_n, io_wdata[7:0]} !== snap) moved = 1'b1;
      if (k == 2) chk("R5 strobe held", 64'(io_ads_n), 64'd0);
      if (k == 3) chk("R5 strobe one io clock", 64'(io_ads_n), 64'd1);
      if (k == 3 + 3 * w) io_rdy_n = 1'b0;
    end
    chk("R6 no early ack", 64'(early), 64'd0);
    chk("R7 held while waiting", 64'(moved), 64'd0);
    @(negedge clk);
    chk("R6 ack due", 64'(cpu_ack), 64'd1);
    chk("R1 lock released", 64'(io_lock_n), 64'd1);
    if (!st[1]) chk("R8 read data replicated", cpu_rdata, {rd, rd});
    cpu_req  = 1'b0;
    io_rdy_n = 1'b1;
    @(negedge clk);
    chk("R6 ack one clock", 64'(cpu_ack), 64'd0);
  endtask

  initial begin
    int highs;
    repeat (4) @(negedge clk);
    chk("R9 reset ads_n", 64'(io_ads_n), 64'd1);
    chk("R9 reset lock_n", 64'(io_lock_n), 64'd1);
    chk("R9 reset be_n", 64'(io_be_n), 64'hF);
    chk("R9 reset io_clk", 64'(io_clk), 64'd0);
    chk("R9 reset ack", 64'(cpu_ack), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (io_clk) highs++;
    end
    chk("R4 io_clk divide by three", 64'(highs), 64'd3);
    for (int c = 0; c < 8; c++)
      for (int h = 0; h < 8; h++)
        for (int m = 0; m < 16; m++)
          do_cycle(c, h, m, (c + h + m) % 3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule